// File: doc/BRIEF.md
# Command-Driven Up/Down Event Counter

This block keeps a single up/down event count of parameterised width (32 bits by default). It has a data register and a small status word beside it. A 4-bit opcode, issued for one cycle with a valid strobe, controls the counter. The opcodes stop and start it, copy its value into the data register, clear it, clear and restart it, take a copy and restart in a single command, and load it from the data register.

Two single-bit inputs carry an already-selected increment event and an already-selected decrement event. A third input, a condition-code flag, decides whether a sample reaches the data register. Software can write the data register, read the data register and status word, and clear the sticky overflow flag.

Commands act on the next clock edge. In the cycle a command is issued, it takes the place of event counting.

Top module: `perf_evt_counter`

## Requirements
- R1: After reset the count is 0, the data register is 0, the counter is stopped (status bit 1 low) and the overflow flag (status bit 0) is low.
- R2: Opcode 4'b0001 sets the counter running and opcode 4'b0000 stops it. While stopped, the count holds whatever the event inputs do.
- R3: While running, with no command in the cycle, the count goes up by one on each cycle that only the increment event is high. It goes down by one on each cycle that only the decrement event is high. It is unchanged when both are high. A level held high counts once per clock.
- R4: Opcode 4'b0010 copies the count into the data register when the condition code is low. The count is not cleared and keeps counting afterwards.
- R5: A sample (4'b0010 or 4'b0110) issued while the condition code is high leaves the data register unchanged.
- R6: Opcode 4'b0100 forces the count to 0 and leaves the counter stopped.
- R7: Opcode 4'b0101 clears the count to 0 and leaves the counter running.
- R8: Opcode 4'b0110 samples under the rule of R4/R5, using the count held before the command, then clears the count and leaves the counter running.
- R9: Opcode 4'b1111 loads the count from the data register and keeps the run/stop state as it was.
- R10: An increment that wraps the count from all-ones to 0 sets the overflow flag, which stays set. A decrement from 0 wraps to all-ones and does not set the flag. A high on the overflow-clear input clears the flag, except in a cycle where a new overflow occurs.
- R11: Any other opcode changes no state.
- R12: A valid command takes priority over event counting in its cycle. Its effect is visible after the next clock edge.
- R13: A software write puts the written value in the data register on the next edge. In the same cycle, a sample that is allowed to write takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Command opcode |
| inc_evt | input | 1 | Selected increment event |
| dec_evt | input | 1 | Selected decrement event |
| cond_code | input | 1 | Condition code; high blocks sample writes |
| data_wr_en | input | 1 | Software write strobe for the data register |
| data_wr_val | input | W | Software write value |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| count_o | output | W | Live count |
| data_o | output | W | Data register |
| status_o | output | 2 | Bit 1 running, bit 0 overflow |

## Verification
On every cycle, the assertions check the following: the count holds while stopped, equal increment and decrement events cancel, reset and reserved opcodes have their effect, a sample blocked by the condition code leaves the data register alone, and the overflow flag stays set. Some behaviours can only be shown by the bench scenarios. These are the exact values that a sample, a preload or a sample-and-restart produce. They also include the wrap from all-ones into overflow after a preload while running, the decrement wrap that raises no flag, and the flag-clear behaviour.

// File: rtl/perf_evt_counter.sv
module perf_evt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [3:0]   cmd_op,
  input  logic         inc_evt,
  input  logic         dec_evt,
  input  logic         cond_code,
  input  logic         data_wr_en,
  input  logic [W-1:0] data_wr_val,
  input  logic         ovf_clr,
  output logic [W-1:0] count_o,
  output logic [W-1:0] data_o,
  output logic [1:0]   status_o
);
  localparam logic [3:0] OP_STOP   = 4'b0000;
  localparam logic [3:0] OP_START  = 4'b0001;
  localparam logic [3:0] OP_SAMPLE = 4'b0010;
  localparam logic [3:0] OP_CLEAR  = 4'b0100;
  localparam logic [3:0] OP_RERUN  = 4'b0101;
  localparam logic [3:0] OP_SMPRUN = 4'b0110;
  localparam logic [3:0] OP_LOAD   = 4'b1111;

  logic [W-1:0] cnt_q, data_q;
  logic         run_q, ovf_q;

  wire step_up = run_q && !cmd_valid && inc_evt && !dec_evt;
  wire step_dn = run_q && !cmd_valid && dec_evt && !inc_evt;
  wire wrap_up = step_up && (&cnt_q);
  wire smp_wr  = cmd_valid && !cond_code &&
                 (cmd_op == OP_SAMPLE || cmd_op == OP_SMPRUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_STOP:   run_q <= 1'b0;
        OP_START:  run_q <= 1'b1;
        OP_CLEAR:  begin cnt_q <= '0; run_q <= 1'b0; end
        OP_RERUN,
        OP_SMPRUN: begin cnt_q <= '0; run_q <= 1'b1; end
        OP_LOAD:   cnt_q <= data_q;
        default:   ;
      endcase
    end else if (step_up) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (step_dn) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          data_q <= '0;
    else if (smp_wr)     data_q <= cnt_q;
    else if (data_wr_en) data_q <= data_wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_q <= 1'b0;
    else if (wrap_up) ovf_q <= 1'b1;
    else if (ovf_clr) ovf_q <= 1'b0;
  end

  assign count_o  = cnt_q;
  assign data_o   = data_q;
  assign status_o = {run_q, ovf_q};
endmodule

module perf_evt_counter_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic [3:0]   cmd_op,
  input logic         inc_evt,
  input logic         dec_evt,
  input logic         cond_code,
  input logic         data_wr_en,
  input logic         ovf_clr,
  input logic [W-1:0] count_o,
  input logic [W-1:0] data_o,
  input logic [1:0]   status_o
);
  wire known_op = cmd_op inside {4'b0000, 4'b0001, 4'b0010, 4'b0100,
                                 4'b0101, 4'b0110, 4'b1111};

  a_r2_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[1] && !cmd_valid |=> $stable(count_o));

  a_r3_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[1] && !cmd_valid && inc_evt && dec_evt |=> $stable(count_o));

  a_r5_cond_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cond_code && !data_wr_en &&
    (cmd_op == 4'b0010 || cmd_op == 4'b0110) |=> $stable(data_o));

  a_r6_clear_stops: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 4'b0100 |=> count_o == '0 && !status_o[1]);

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] && !ovf_clr |=> status_o[0]);

  a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !known_op |=> $stable(count_o) && $stable(status_o[1]));
endmodule

bind perf_evt_counter perf_evt_counter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .inc_evt(inc_evt), .dec_evt(dec_evt), .cond_code(cond_code),
  .data_wr_en(data_wr_en), .ovf_clr(ovf_clr), .count_o(count_o),
  .data_o(data_o), .status_o(status_o));

// File: tb/tb_perf_evt_counter.sv
module tb_perf_evt_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = 4'b0;
  logic        inc_evt = 1'b0, dec_evt = 1'b0, cond_code = 1'b0;
  logic        data_wr_en = 1'b0, ovf_clr = 1'b0;
  logic [31:0] data_wr_val = '0;
  logic [31:0] count_o, data_o;
  logic [1:0]  status_o;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  perf_evt_counter #(.W(32)) dut (.*);

  // {valid, op, inc, dec, cond, exp count, exp data, exp running}
  localparam int NV = 20;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 4'b0001, 3'b100, 32'd0, 32'd0, 1'b1},  // R2 R12 start, inc ignored
    {1'b0, 4'b0000, 3'b100, 32'd1, 32'd0, 1'b1},  // R3
    {1'b0, 4'b0000, 3'b100, 32'd2, 32'd0, 1'b1},  // R3 held level
    {1'b0, 4'b0000, 3'b110, 32'd2, 32'd0, 1'b1},  // R3 cancel
    {1'b0, 4'b0000, 3'b010, 32'd1, 32'd0, 1'b1},  // R3 dec
    {1'b0, 4'b0000, 3'b100, 32'd2, 32'd0, 1'b1},
    {1'b1, 4'b0010, 3'b100, 32'd2, 32'd2, 1'b1},  // R4 R12
    {1'b0, 4'b0000, 3'b100, 32'd3, 32'd2, 1'b1},  // R4 keeps counting
    {1'b1, 4'b0010, 3'b001, 32'd3, 32'd2, 1'b1},  // R5
    {1'b1, 4'b0011, 3'b100, 32'd3, 32'd2, 1'b1},  // R11
    {1'b1, 4'b0000, 3'b000, 32'd3, 32'd2, 1'b0},  // R2 stop
    {1'b0, 4'b0000, 3'b100, 32'd3, 32'd2, 1'b0},  // R2 held
    {1'b1, 4'b1111, 3'b000, 32'd2, 32'd2, 1'b0},  // R9 stays stopped
    {1'b1, 4'b0101, 3'b000, 32'd0, 32'd2, 1'b1},  // R7
    {1'b0, 4'b0000, 3'b100, 32'd1, 32'd2, 1'b1},
    {1'b0, 4'b0000, 3'b100, 32'd2, 32'd2, 1'b1},
    {1'b1, 4'b0110, 3'b000, 32'd0, 32'd2, 1'b1},  // R8
    {1'b0, 4'b0000, 3'b100, 32'd1, 32'd2, 1'b1},
    {1'b1, 4'b0100, 3'b000, 32'd0, 32'd2, 1'b0},  // R6
    {1'b0, 4'b0000, 3'b100, 32'd0, 32'd2, 1'b0}   // R6 stays stopped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [3:0] op, input logic i,
                     input logic d, input logic c);
    cmd_valid = v; cmd_op = op; inc_evt = i; dec_evt = d; cond_code = c;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; inc_evt = 1'b0; dec_evt = 1'b0; cond_code = 1'b0;
    data_wr_en = 1'b0; ovf_clr = 1'b0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 count", count_o, 32'd0);
    chk("R1 data", data_o, 32'd0);
    chk("R1 status", {30'd0, status_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      cyc(VEC[k][72], VEC[k][71:68], VEC[k][67], VEC[k][66], VEC[k][65]);
      chk($sformatf("R2-vector %0d count", k), count_o, VEC[k][64:33]);
      chk($sformatf("R4 R8 R9 vector %0d data", k), data_o, VEC[k][32:1]);
      chk($sformatf("R2 vector %0d running", k), {31'd0, status_o[1]}, {31'd0, VEC[k][0]});
    end

    // R13 software write; R9 preload while running; R10 overflow
    data_wr_en = 1'b1; data_wr_val = 32'hFFFF_FFFE;
    cyc(1'b1, 4'b0001, 1'b0, 1'b0, 1'b0);
    chk("R13 write", data_o, 32'hFFFF_FFFE);
    cyc(1'b1, 4'b1111, 1'b0, 1'b0, 1'b0);
    chk("R9 preload running", count_o, 32'hFFFF_FFFE);
    chk("R9 run kept", {31'd0, status_o[1]}, 32'd1);
    cyc(1'b0, 4'b0, 1'b1, 1'b0, 1'b0);
    chk("R10 pre-wrap flag", {31'd0, status_o[0]}, 32'd0);
    cyc(1'b0, 4'b0, 1'b1, 1'b0, 1'b0);
    chk("R10 wrap count", count_o, 32'd0);
    chk("R10 wrap flag", {31'd0, status_o[0]}, 32'd1);
    cyc(1'b0, 4'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 sticky", {31'd0, status_o[0]}, 32'd1);
    ovf_clr = 1'b1;
    cyc(1'b0, 4'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 clear", {31'd0, status_o[0]}, 32'd0);
    cyc(1'b0, 4'b0, 1'b0, 1'b1, 1'b0);
    chk("R10 dec wrap count", count_o, 32'hFFFF_FFFF);
    chk("R10 dec wrap no flag", {31'd0, status_o[0]}, 32'd0);

    // R13 sample beats software write; R8 with cond high keeps data
    data_wr_en = 1'b1; data_wr_val = 32'h1234_5678;
    cyc(1'b1, 4'b0010, 1'b0, 1'b0, 1'b0);
    chk("R13 sample precedence", data_o, 32'hFFFF_FFFF);
    cyc(1'b1, 4'b0110, 1'b0, 1'b0, 1'b1);
    chk("R8 cond high data", data_o, 32'hFFFF_FFFF);
    chk("R8 cond high count", count_o, 32'd0);
    chk("R8 running", {31'd0, status_o[1]}, 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule